// File: doc/BRIEF.md
# Control-Flow Next-Address Unit

This unit resolves where execution goes after a control-flow instruction and how many cycles that instruction occupies. Each cycle in which `in_valid` is high, it takes the current program counter, an instruction class code and all operands the class might need: a signed word offset, the status byte, the result of a register compare, a selected register bit, a selected I/O bit, a 16-bit pointer, a popped return address, an absolute target, and a flag telling whether the instruction after the current one is two words long. One clock later it presents the next program counter, a taken flag, the cycle count and a strobe that asks the core to set the global interrupt enable.

Conditional branches test one status bit against a wanted polarity. The signed-compare selection does not read the stored sign bit but derives it from the negative and overflow bits. Skip instructions move the counter past the following instruction, which takes one or two words, and their cycle count grows with that length. Stack storage and instruction fetch sit outside the unit.

Top module: `bnpc_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises until a valid instruction is registered, `out_valid`, `next_pc`, `taken`, `cycles` and `set_ie` are all zero.
- R2: Class 0 (relative jump) and class 1 (relative call) give `next_pc = pc + sign_extend(offset) + 1`, wrapping at the PC width, with `taken` high and 2 or 3 cycles respectively.
- R3: Class 2 (indirect jump) and class 3 (indirect call) give `next_pc = zptr`, with `taken` high and 2 or 3 cycles respectively.
- R4: Class 4 (direct jump) and class 5 (direct call) give `next_pc = abs_target`, with `taken` high and 3 or 4 cycles respectively.
- R5: Class 6 (return) and class 7 (return from interrupt) give `next_pc = ret_addr`, `taken` high and 4 cycles; `set_ie` is high only for class 7.
- R6: Class 8 (conditional branch) is taken when `sreg[flag_sel]` equals `flag_pol`; taken gives `pc + sign_extend(offset) + 1` in 2 cycles, not taken gives `pc + 1` in 1 cycle. Status bits: 0 carry, 1 zero, 2 negative, 3 overflow, 4 sign, 5 half carry, 6 T, 7 interrupt enable.
- R7: With `flag_sel = 4` the tested value is `sreg[2] XOR sreg[3]`; the stored `sreg[4]` has no effect on the outcome.
- R8: A skip whose condition holds gives `pc + 2` in 2 cycles, or `pc + 3` in 3 cycles when `next_two_word` is high, with `taken` high.
- R9: A skip whose condition fails gives `pc + 1` in 1 cycle with `taken` low, whatever `next_two_word` is.
- R10: The skip condition is `cmp_eq` for class 9, `reg_bit == skip_pol` for class 10 and `io_bit == skip_pol` for class 11; each class ignores the other two condition inputs.
- R11: Outputs change one clock after a cycle with `in_valid` high; after a cycle with `in_valid` low, `out_valid` is low and the other outputs keep their values.
- R12: Class codes 12 to 15 give `pc + 1`, 1 cycle, `taken` low, `set_ie` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction operands are present this cycle |
| cls | input | 4 | Instruction class code |
| pc | input | PC_W (16) | Address of the current instruction |
| offset | input | OFF_W (12) | Signed relative word offset |
| sreg | input | 8 | Status byte |
| flag_sel | input | 3 | Status bit tested by a conditional branch |
| flag_pol | input | 1 | Branch when the tested bit equals this value |
| cmp_eq | input | 1 | The two compared registers are equal |
| reg_bit | input | 1 | Selected bit of a register |
| io_bit | input | 1 | Selected bit of an I/O register |
| skip_pol | input | 1 | Skip when the tested bit equals this value |
| next_two_word | input | 1 | The following instruction is two words long |
| zptr | input | PTR_W (16) | Pointer used by indirect transfers |
| ret_addr | input | PC_W (16) | Address popped from the stack |
| abs_target | input | PC_W (16) | Absolute target of a direct transfer |
| out_valid | output | 1 | Outputs belong to the last valid instruction |
| next_pc | output | PC_W (16) | Resolved next program counter |
| taken | output | 1 | Control flow left the sequential path |
| cycles | output | 3 | Cycles the instruction takes |
| set_ie | output | 1 | Set the global interrupt enable |

## Verification
The bench aims at wrap-around of relative arithmetic at both ends of the address space, including the most negative and most positive offsets; a unit that zero-extended the offset or failed to wrap would jump far from the expected address. It checks the signed-compare selection with the stored sign bit set opposite to N XOR V, which catches a design reading bit 4 directly. Skips are checked with both next-instruction lengths and with the unused condition inputs set against the outcome, exposing a skip of the wrong size, a wrong cycle count, or a condition wired to the wrong source. The hold behaviour with `in_valid` low and the return-from-interrupt strobe are checked at the ports.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    typedef enum logic [3:0] {
        CL_RJMP    = 4'd0,
        CL_RCALL   = 4'd1,
        CL_IJMP    = 4'd2,
        CL_ICALL   = 4'd3,
        CL_JMP     = 4'd4,
        CL_CALL    = 4'd5,
        CL_RET     = 4'd6,
        CL_RETI    = 4'd7,
        CL_BRANCH  = 4'd8,
        CL_SKIP_EQ = 4'd9,
        CL_SKIP_RB = 4'd10,
        CL_SKIP_IO = 4'd11
    } cls_e;

    localparam int CYC_W  = 3;
    localparam int SREG_W = 8;
    localparam int SEL_W  = 3;
    // status bit positions that the condition logic decodes
    localparam int N_POS  = 2;
    localparam int V_POS  = 3;
    localparam int S_POS  = 4;

endpackage

// File: rtl/bnpc_cond.sv
module bnpc_cond
    import bnpc_pkg::*;
(
    input  logic [3:0]        cls,
    input  logic [SREG_W-1:0] sreg,
    input  logic [SEL_W-1:0]  flag_sel,
    input  logic              flag_pol,
    input  logic              cmp_eq,
    input  logic              reg_bit,
    input  logic              io_bit,
    input  logic              skip_pol,
    output logic              hit
);

    logic flag_val;

    always_comb begin
        // signed selection derives its value rather than trusting the stored bit
        if (flag_sel == SEL_W'(S_POS)) begin
            flag_val = sreg[N_POS] ^ sreg[V_POS];
        end else begin
            flag_val = sreg[flag_sel];
        end
    end

    always_comb begin
        unique case (cls_e'(cls))
            CL_BRANCH:  hit = (flag_val == flag_pol);
            CL_SKIP_EQ: hit = cmp_eq;
            CL_SKIP_RB: hit = (reg_bit == skip_pol);
            CL_SKIP_IO: hit = (io_bit == skip_pol);
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target #(
    parameter int PC_W  = 16,
    parameter int OFF_W = 12,
    parameter int PTR_W = 16
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  logic [PTR_W-1:0] zptr,
    output logic [PC_W-1:0]  rel_tgt,
    output logic [PC_W-1:0]  ptr_tgt,
    output logic [PC_W-1:0]  seq1,
    output logic [PC_W-1:0]  seq2,
    output logic [PC_W-1:0]  seq3
);

    logic [PC_W-1:0] off_ext;

    generate
        if (PC_W > OFF_W) begin : g_sext
            assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[PC_W-1:0];
        end

        if (PC_W > PTR_W) begin : g_zext
            assign ptr_tgt = {{(PC_W-PTR_W){1'b0}}, zptr};
        end else begin : g_ptrunc
            assign ptr_tgt = zptr[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        seq1    = pc + PC_W'(1);
        seq2    = pc + PC_W'(2);
        seq3    = pc + PC_W'(3);
        rel_tgt = pc + off_ext + PC_W'(1);
    end

endmodule

// File: rtl/bnpc_top.sv
module bnpc_top
    import bnpc_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int OFF_W = 12,
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        cls,
    input  logic [PC_W-1:0]   pc,
    input  logic [OFF_W-1:0]  offset,
    input  logic [7:0]        sreg,
    input  logic [2:0]        flag_sel,
    input  logic              flag_pol,
    input  logic              cmp_eq,
    input  logic              reg_bit,
    input  logic              io_bit,
    input  logic              skip_pol,
    input  logic              next_two_word,
    input  logic [PTR_W-1:0]  zptr,
    input  logic [PC_W-1:0]   ret_addr,
    input  logic [PC_W-1:0]   abs_target,
    output logic              out_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic              taken,
    output logic [CYC_W-1:0]  cycles,
    output logic              set_ie
);

    typedef struct packed {
        logic             vld;
        logic [PC_W-1:0]  npc;
        logic             tk;
        logic [CYC_W-1:0] cyc;
        logic             ie;
    } res_t;

    res_t res_d, res_q;

    logic            hit;
    logic [PC_W-1:0] rel_tgt, ptr_tgt, seq1, seq2, seq3;
    logic            is_skip;

    bnpc_cond u_cond (
        .cls      (cls),
        .sreg     (sreg),
        .flag_sel (flag_sel),
        .flag_pol (flag_pol),
        .cmp_eq   (cmp_eq),
        .reg_bit  (reg_bit),
        .io_bit   (io_bit),
        .skip_pol (skip_pol),
        .hit      (hit)
    );

    bnpc_target #(
        .PC_W  (PC_W),
        .OFF_W (OFF_W),
        .PTR_W (PTR_W)
    ) u_tgt (
        .pc      (pc),
        .offset  (offset),
        .zptr    (zptr),
        .rel_tgt (rel_tgt),
        .ptr_tgt (ptr_tgt),
        .seq1    (seq1),
        .seq2    (seq2),
        .seq3    (seq3)
    );

    assign is_skip = (cls == CL_SKIP_EQ) || (cls == CL_SKIP_RB) || (cls == CL_SKIP_IO);

    always_comb begin
        res_d     = res_q;
        res_d.vld = 1'b0;
        if (in_valid) begin
            res_d.vld = 1'b1;
            res_d.npc = seq1;
            res_d.tk  = 1'b1;
            res_d.cyc = CYC_W'(1);
            res_d.ie  = 1'b0;
            unique case (cls_e'(cls))
                CL_RJMP:  begin res_d.npc = rel_tgt;    res_d.cyc = CYC_W'(2); end
                CL_RCALL: begin res_d.npc = rel_tgt;    res_d.cyc = CYC_W'(3); end
                CL_IJMP:  begin res_d.npc = ptr_tgt;    res_d.cyc = CYC_W'(2); end
                CL_ICALL: begin res_d.npc = ptr_tgt;    res_d.cyc = CYC_W'(3); end
                CL_JMP:   begin res_d.npc = abs_target; res_d.cyc = CYC_W'(3); end
                CL_CALL:  begin res_d.npc = abs_target; res_d.cyc = CYC_W'(4); end
                CL_RET:   begin res_d.npc = ret_addr;   res_d.cyc = CYC_W'(4); end
                CL_RETI:  begin
                    res_d.npc = ret_addr;
                    res_d.cyc = CYC_W'(4);
                    res_d.ie  = 1'b1;
                end
                CL_BRANCH: begin
                    if (hit) begin
                        res_d.npc = rel_tgt;
                        res_d.cyc = CYC_W'(2);
                    end else begin
                        res_d.tk  = 1'b0;
                    end
                end
                CL_SKIP_EQ, CL_SKIP_RB, CL_SKIP_IO: begin
                    if (!hit) begin
                        res_d.tk  = 1'b0;
                    end else if (next_two_word) begin
                        res_d.npc = seq3;
                        res_d.cyc = CYC_W'(3);
                    end else begin
                        res_d.npc = seq2;
                        res_d.cyc = CYC_W'(2);
                    end
                end
                default: res_d.tk = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign next_pc   = res_q.npc;
    assign taken     = res_q.tk;
    assign cycles    = res_q.cyc;
    assign set_ie    = res_q.ie;

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(next_pc) && $stable(cycles));

    // R9
    not_taken_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !taken |-> cycles == CYC_W'(1));

    // R5
    set_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && set_ie |-> taken && cycles == CYC_W'(4));

    // R2
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cycles >= CYC_W'(1) && cycles <= CYC_W'(4));

    // R8
    skip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && is_skip |=> next_pc == PC_W'($past(pc) + PC_W'(cycles)));

endmodule

// File: tb/sim_bnpc_top.sv
module sim_bnpc_top;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W  = 16;
    localparam int OFF_W = 12;
    localparam int PTR_W = 16;
    localparam int NVEC  = 23;

    typedef struct packed {
        logic [3:0]  cls;
        logic [15:0] pc;
        logic [11:0] off;
        logic [7:0]  sreg;
        logic [2:0]  sel;
        logic        pol;
        logic        eq;
        logic        rb;
        logic        iob;
        logic        spol;
        logic        two;
        logic [15:0] z;
        logic [15:0] ret;
        logic [15:0] abst;
        logic [15:0] epc;
        logic        etk;
        logic [2:0]  ecyc;
        logic        eie;
    } vec_t;

    // cls pc off sreg sel pol eq rb iob spol two z ret abs | epc etk ecyc eie
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  16'h0100, 12'h010, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0111, 1'b1, 3'd2, 1'b0}, // R2
        '{4'd0,  16'h0005, 12'hFF0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'hFFF6, 1'b1, 3'd2, 1'b0}, // R2 wrap down
        '{4'd1,  16'hFFFF, 12'h001, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0001, 1'b1, 3'd3, 1'b0}, // R2 wrap up
        '{4'd2,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0, 16'h0, 16'h1234, 1'b1, 3'd2, 1'b0}, // R3
        '{4'd3,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h0, 16'h0, 16'hBEEF, 1'b1, 3'd3, 1'b0}, // R3
        '{4'd4,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h4000, 16'h4000, 1'b1, 3'd3, 1'b0}, // R4
        '{4'd5,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0042, 16'h0042, 1'b1, 3'd4, 1'b0}, // R4
        '{4'd6,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0777, 16'h0, 16'h0777, 1'b1, 3'd4, 1'b0}, // R5
        '{4'd7,  16'h0300, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0888, 16'h0, 16'h0888, 1'b1, 3'd4, 1'b1}, // R5
        '{4'd8,  16'h0200, 12'h7FF, 8'h02, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0A00, 1'b1, 3'd2, 1'b0}, // R6
        '{4'd8,  16'h0200, 12'h7FF, 8'h00, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0201, 1'b0, 3'd1, 1'b0}, // R6
        '{4'd8,  16'h0010, 12'h800, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'hF811, 1'b1, 3'd2, 1'b0}, // R6
        '{4'd8,  16'h0300, 12'h002, 8'h1C, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0303, 1'b1, 3'd2, 1'b0}, // R7
        '{4'd8,  16'h0300, 12'h004, 8'h04, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0305, 1'b1, 3'd2, 1'b0}, // R7
        '{4'd8,  16'h0300, 12'h004, 8'h10, 3'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0301, 1'b0, 3'd1, 1'b0}, // R7
        '{4'd9,  16'h0400, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0402, 1'b1, 3'd2, 1'b0}, // R8
        '{4'd9,  16'h0400, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0403, 1'b1, 3'd3, 1'b0}, // R8
        '{4'd9,  16'h0400, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0401, 1'b0, 3'd1, 1'b0}, // R9 R10
        '{4'd10, 16'hFFFE, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0000, 1'b1, 3'd2, 1'b0}, // R10
        '{4'd10, 16'hFFFE, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1'b0, 3'd1, 1'b0}, // R10
        '{4'd11, 16'h0010, 12'h000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0013, 1'b1, 3'd3, 1'b0}, // R10
        '{4'd11, 16'h0010, 12'h000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0, 16'h0, 16'h0011, 1'b0, 3'd1, 1'b0}, // R10
        '{4'd15, 16'h0050, 12'h7FF, 8'hFF, 3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0, 16'h0, 16'h0, 16'h0051, 1'b0, 3'd1, 1'b0}  // R12
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [3:0]        cls = '0;
    logic [PC_W-1:0]   pc = '0;
    logic [OFF_W-1:0]  offset = '0;
    logic [7:0]        sreg = '0;
    logic [2:0]        flag_sel = '0;
    logic              flag_pol = 1'b0;
    logic              cmp_eq = 1'b0;
    logic              reg_bit = 1'b0;
    logic              io_bit = 1'b0;
    logic              skip_pol = 1'b0;
    logic              next_two_word = 1'b0;
    logic [PTR_W-1:0]  zptr = '0;
    logic [PC_W-1:0]   ret_addr = '0;
    logic [PC_W-1:0]   abs_target = '0;
    logic              out_valid;
    logic [PC_W-1:0]   next_pc;
    logic              taken;
    logic [2:0]        cycles;
    logic              set_ie;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bnpc_top #(.PC_W(PC_W), .OFF_W(OFF_W), .PTR_W(PTR_W)) u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .cls (cls), .pc (pc),
        .offset (offset), .sreg (sreg), .flag_sel (flag_sel), .flag_pol (flag_pol),
        .cmp_eq (cmp_eq), .reg_bit (reg_bit), .io_bit (io_bit), .skip_pol (skip_pol),
        .next_two_word (next_two_word), .zptr (zptr), .ret_addr (ret_addr),
        .abs_target (abs_target), .out_valid (out_valid), .next_pc (next_pc),
        .taken (taken), .cycles (cycles), .set_ie (set_ie)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cls = v.cls; pc = v.pc; offset = v.off; sreg = v.sreg;
        flag_sel = v.sel; flag_pol = v.pol; cmp_eq = v.eq; reg_bit = v.rb;
        io_bit = v.iob; skip_pol = v.spol; next_two_word = v.two;
        zptr = v.z; ret_addr = v.ret; abs_target = v.abst;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (2) @(negedge clk);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 next_pc", 32'(next_pc), 32'd0);
        check("R1 taken/cycles/set_ie", {taken, cycles, set_ie}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {out_valid, next_pc, taken, cycles, set_ie}, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check($sformatf("R11 valid v%0d", i), 32'(out_valid), 32'd1);
            check($sformatf("R2-class next_pc v%0d", i), 32'(next_pc), 32'(VECS[i].epc));
            check($sformatf("taken v%0d", i), 32'(taken), 32'(VECS[i].etk));
            check($sformatf("cycles v%0d", i), 32'(cycles), 32'(VECS[i].ecyc));
            check($sformatf("R5 set_ie v%0d", i), 32'(set_ie), 32'(VECS[i].eie));
        end

        // R11: a cycle without in_valid holds the result of the last vector
        drive(VECS[0]);
        in_valid = 1'b0;
        @(negedge clk);
        check("R11 valid low", 32'(out_valid), 32'd0);
        check("R11 hold pc", 32'(next_pc), 32'h0051);
        check("R11 hold cycles", 32'(cycles), 32'd1);

        // R5: return from interrupt then plain return clears the strobe
        drive(VECS[8]);
        in_valid = 1'b1;
        @(negedge clk);
        check("R5 reti strobe", 32'(set_ie), 32'd1);
        drive(VECS[7]);
        @(negedge clk);
        check("R5 ret no strobe", 32'(set_ie), 32'd0);

        // R9: failed skip with two-word flag on and off gives the same result
        drive(VECS[17]);
        next_two_word = 1'b0;
        @(negedge clk);
        check("R9 skip fail pc", 32'(next_pc), 32'h0401);
        check("R9 skip fail cycles", 32'(cycles), 32'd1);

        // R1: reset mid-run clears outputs
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 re-reset", {out_valid, next_pc, taken, cycles, set_ie}, 32'd0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule